// File: doc/BRIEF.md
# 8b/10b Character Encoder with Per-Character Disparity Control

This block turns one byte plus a control flag into one DC-balanced 10-bit line character on every clock. It holds the running disparity of the stream and picks the positive or negative form of each character from it. Both the 256 data characters and the 12 legal control characters are covered. It also chooses the alternate 3b/4b form for D.x.7 where that form is needed to bound run length. A control request for a byte that has no control character is flagged on an error output. The block still sends the byte's data encoding in that case.

Each character can override the disparity it is encoded from. It can use the running value, the inverse of the running value, or a fixed negative or positive value. This lets a link emit patterns such as two positive K28.5 characters followed by two negative ones. A bypass input turns the encoder off and sends a raw 10-bit word to the line unchanged. All three outputs come from one register stage: the character, the error flag and the running disparity after that character.

Top module: `line_encoder_8b10b`

## Requirements
- R1: During reset, and in the first cycle after it, `code_out` is 0, `ctrl_err` is 0 and `run_disp` is 0. The value 0 means negative disparity and 1 means positive.
- R2: With `ctrl_k` low, the byte `sym_in[7:0]` is encoded as data character D.x.y, where x = `sym_in[4:0]` and y = `sym_in[7:5]`. The code is taken from the standard 5b/6b and 3b/4b tables for the disparity in use. The 6-bit sub-block abcdei sits on `code_out[9:4]` with a on bit 9. The 4-bit sub-block fghj sits on `code_out[3:0]` with f on bit 3.
- R3: With `ctrl_k` high, the bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC (K28.0 to K28.7) and 0xF7, 0xFB, 0xFD, 0xFE (K23.7, K27.7, K29.7, K30.7) give their control characters. For example, K28.5 from negative disparity is 0011111010.
- R4: With `ctrl_k` high and any other byte, the output is the byte's data character and disparity updates as for data. `ctrl_err` is high for that character's cycle only.
- R5: Every encoded character has 4, 5 or 6 ones. `run_disp` follows the character's balance: 1 after six ones, 0 after four ones, and unchanged from the disparity in use after five ones.
- R6: D.x.7 uses fghj = 0111 (or 1000 from positive) when x is 17, 18 or 20 and the disparity after the 6-bit sub-block is negative. It also uses that form when x is 11, 13 or 14 and that disparity is positive. Otherwise D.x.7 uses 1110/0001.
- R7: `{disp_mode, disp_val}` selects the starting disparity of each character. 00 uses the running value, 01 uses its inverse, 10 uses negative and 11 uses positive. `run_disp` then continues from the character as encoded.
- R8: With `bypass` high, `sym_in[9:0]` appears unchanged on `code_out`. `run_disp` holds its value, `ctrl_err` is 0, and `ctrl_k`, `disp_mode` and `disp_val` have no effect.
- R9: All three outputs change together one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 10 | Byte in bits 7:0 when encoding; whole raw word when bypassed |
| ctrl_k | input | 1 | Requests a control character for this byte |
| disp_mode | input | 1 | 1 selects a fixed starting disparity |
| disp_val | input | 1 | Fixed disparity value, or invert request when disp_mode is 0 |
| bypass | input | 1 | Pass sym_in straight to the line |
| code_out | output | 10 | Line character |
| ctrl_err | output | 1 | Illegal control request in this character |
| run_disp | output | 1 | Running disparity after this character (1 = positive) |

## Verification
Two functions can act in the same cycle: an illegal control request and a disparity override. The bench sends illegal control bytes with forced-positive, forced-negative and inverted disparity. It expects the data character built from the forced disparity, the error flag on that one character, and a running disparity that continues from the forced choice. A long random stream mixes control requests, overrides and bypass words. Each character is judged against an independent table model that keeps its own disparity.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

    localparam int BYTE_W  = 8;
    localparam int LINE_W  = 10;
    localparam int SUB6_W  = 6;
    localparam int SUB4_W  = LINE_W - SUB6_W;
    localparam int X_W     = 5;
    localparam int Y_W     = BYTE_W - X_W;

    localparam logic [X_W-1:0] X_K28 = 5'd28;

    // Starting-disparity selector: {mode, value}
    typedef enum logic [1:0] {
        DSEL_RUN = 2'b00,
        DSEL_INV = 2'b01,
        DSEL_NEG = 2'b10,
        DSEL_POS = 2'b11
    } dsel_e;

    typedef struct packed {
        logic [SUB6_W-1:0] abcdei;
        logic [SUB4_W-1:0] fghj;
    } code_t;

    // 5b/6b code for a negative starting disparity
    function automatic logic [SUB6_W-1:0] sub6_neg(input logic [X_W-1:0] x);
        logic [SUB6_W-1:0] c;
        case (x)
            5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;  default: c = 6'b101011;
        endcase
        return c;
    endfunction

    // 3b/4b data code (primary D.x.7) for a negative sub-block disparity
    function automatic logic [SUB4_W-1:0] sub4_data_neg(input logic [Y_W-1:0] y);
        logic [SUB4_W-1:0] c;
        case (y)
            3'd0: c = 4'b1011;  3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;  3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;  3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;  default: c = 4'b1110;
        endcase
        return c;
    endfunction

    // 3b/4b control code for a negative sub-block disparity
    function automatic logic [SUB4_W-1:0] sub4_ctrl_neg(input logic [Y_W-1:0] y);
        logic [SUB4_W-1:0] c;
        case (y)
            3'd0: c = 4'b1011;  3'd1: c = 4'b0110;
            3'd2: c = 4'b1010;  3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;  3'd5: c = 4'b0101;
            3'd6: c = 4'b1001;  default: c = 4'b0111;
        endcase
        return c;
    endfunction

    function automatic logic ctrl_legal(input logic [BYTE_W-1:0] b);
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        x = b[X_W-1:0];
        y = b[BYTE_W-1:X_W];
        return (x == X_K28) ||
               ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                (x == 5'd29) || (x == 5'd30)));
    endfunction

endpackage

// File: rtl/enc_disp_select.sv
module enc_disp_select
    import enc8b10b_pkg::*;
(
    input  logic  rd_run,
    input  dsel_e sel,
    output logic  rd_start
);
    always_comb begin
        case (sel)
            DSEL_RUN: rd_start = rd_run;
            DSEL_INV: rd_start = ~rd_run;
            DSEL_NEG: rd_start = 1'b0;
            default:  rd_start = 1'b1;
        endcase
    end
endmodule

// File: rtl/enc_5b6b.sv
module enc_5b6b
    import enc8b10b_pkg::*;
(
    input  logic [X_W-1:0]    x,
    input  logic              k_ok,
    input  logic              rd_in,
    output logic [SUB6_W-1:0] code6,
    output logic              rd_mid
);
    logic [SUB6_W-1:0] base;
    logic              unbal;
    logic              swap;

    always_comb begin
        base  = (k_ok && (x == X_K28)) ? 6'b001111 : sub6_neg(x);
        unbal = ($countones(base) != 3);
        // D.07 is balanced yet still has two forms
        swap  = unbal || (x == 5'd7);
        code6 = (rd_in && swap) ? ~base : base;
        rd_mid = rd_in ^ unbal;
    end
endmodule

// File: rtl/enc_3b4b.sv
module enc_3b4b
    import enc8b10b_pkg::*;
(
    input  logic [Y_W-1:0]    y,
    input  logic [X_W-1:0]    x,
    input  logic              k_ok,
    input  logic              rd_mid,
    output logic [SUB4_W-1:0] code4,
    output logic              rd_out
);
    logic              alt7;
    logic [SUB4_W-1:0] base;
    logic              unbal;
    logic              swap;

    always_comb begin
        alt7 = (y == 3'd7) &&
               (k_ok ||
                (!rd_mid && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
                ( rd_mid && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))));
        if (k_ok)      base = sub4_ctrl_neg(y);
        else if (alt7) base = 4'b0111;
        else           base = sub4_data_neg(y);
        unbal  = ($countones(base) != 2);
        swap   = k_ok || unbal || (y == 3'd3);
        code4  = (rd_mid && swap) ? ~base : base;
        rd_out = rd_mid ^ unbal;
    end
endmodule

// File: rtl/line_encoder_8b10b.sv
module line_encoder_8b10b
    import enc8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] sym_in,
    input  logic              ctrl_k,
    input  logic              disp_mode,
    input  logic              disp_val,
    input  logic              bypass,
    output logic [LINE_W-1:0] code_out,
    output logic              ctrl_err,
    output logic              run_disp
);
    logic [X_W-1:0]    x_in;
    logic [Y_W-1:0]    y_in;
    logic              legal;
    logic              k_ok;
    logic              rd_start;
    logic              rd_mid;
    logic              rd_end;
    logic [SUB6_W-1:0] c6;
    logic [SUB4_W-1:0] c4;
    dsel_e             sel;

    code_t code_q;
    logic  rd_q;
    logic  err_q;

    assign x_in  = sym_in[X_W-1:0];
    assign y_in  = sym_in[BYTE_W-1:X_W];
    assign legal = ctrl_legal(sym_in[BYTE_W-1:0]);
    assign k_ok  = ctrl_k & legal;
    assign sel   = dsel_e'({disp_mode, disp_val});

    enc_disp_select u_sel (
        .rd_run   (rd_q),
        .sel      (sel),
        .rd_start (rd_start)
    );

    enc_5b6b u_hi (
        .x      (x_in),
        .k_ok   (k_ok),
        .rd_in  (rd_start),
        .code6  (c6),
        .rd_mid (rd_mid)
    );

    enc_3b4b u_lo (
        .y      (y_in),
        .x      (x_in),
        .k_ok   (k_ok),
        .rd_mid (rd_mid),
        .code4  (c4),
        .rd_out (rd_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            rd_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (bypass) begin
            code_q <= sym_in;
            err_q  <= 1'b0;
        end else begin
            code_q <= {c6, c4};
            rd_q   <= rd_end;
            err_q  <= ctrl_k & ~legal;
        end
    end

    assign code_out = code_q;
    assign ctrl_err = err_q;
    assign run_disp = rd_q;

    // R1: reset leaves a zero character and negative disparity
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (code_out == '0 && !run_disp && !ctrl_err));

    // R5: encoded characters keep the line within +/-1 of balance
    p_balance_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bypass)) |->
            ($countones(code_out) >= 4 && $countones(code_out) <= 6));

    // R5: heavy or light characters leave the matching disparity
    p_disp_follows_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bypass) && $countones(code_out) != 5) |->
            (run_disp == ($countones(code_out) == 6)));

    // R4: the error flag only follows a control request in encode mode
    p_err_source_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl_err |-> ($past(ctrl_k) && !$past(bypass)));

    // R8: bypass words never move the running disparity
    p_bypass_hold_r8: assert property (@(posedge clk) disable iff (rst)
        bypass |=> $stable(run_disp));
endmodule

// File: tb/line_encoder_8b10b_test.sv
`timescale 1ns/1ps
module line_encoder_8b10b_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sym_in = '0;
    logic       ctrl_k = 1'b0;
    logic       disp_mode = 1'b0;
    logic       disp_val = 1'b0;
    logic       bypass = 1'b0;
    logic [9:0] code_out;
    logic       ctrl_err;
    logic       run_disp;

    int tests = 0;
    int fails = 0;
    logic model_rd = 1'b0;
    bit done = 0;

    typedef struct {
        logic [9:0] code;
        logic       rd;
        logic       err;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    line_encoder_8b10b uut (
        .clk(clk), .rst(rst), .sym_in(sym_in), .ctrl_k(ctrl_k),
        .disp_mode(disp_mode), .disp_val(disp_val), .bypass(bypass),
        .code_out(code_out), .ctrl_err(ctrl_err), .run_disp(run_disp)
    );

    function automatic logic [5:0] m6(input logic [4:0] x);
        logic [5:0] t [32] = '{6'o47, 6'o35, 6'o55, 6'o61, 6'o65, 6'o51,
                               6'o31, 6'o70, 6'o71, 6'o45, 6'o25, 6'o64,
                               6'o15, 6'o54, 6'o34, 6'o27, 6'o33, 6'o43,
                               6'o23, 6'o62, 6'o13, 6'o52, 6'o32, 6'o72,
                               6'o63, 6'o46, 6'o26, 6'o66, 6'o16, 6'o56,
                               6'o36, 6'o53};
        return t[x];
    endfunction

    // returns {err, rd_after, code}
    function automatic logic [11:0] ref_enc(input logic [7:0] b, input logic k,
                                            input logic rd0);
        logic [4:0] x;
        logic [2:0] y;
        logic legal, kk, rdm, rd1, alt;
        logic [5:0] s6;
        logic [3:0] s4;
        logic [3:0] dneg [8] = '{4'hB, 4'h9, 4'h5, 4'hC, 4'hD, 4'hA, 4'h6, 4'hE};
        logic [3:0] dpos [8] = '{4'h4, 4'h9, 4'h5, 4'h3, 4'h2, 4'hA, 4'h6, 4'h1};
        logic [3:0] kneg [8] = '{4'hB, 4'h6, 4'hA, 4'hC, 4'hD, 4'h5, 4'h9, 4'h7};
        int n;
        x = b[4:0];
        y = b[7:5];
        legal = (x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30));
        kk = k && legal;
        s6 = (kk && x == 28) ? 6'b001111 : m6(x);
        if (rd0 && ($countones(s6) != 3 || x == 7)) s6 = ~s6;
        n = $countones(s6);
        rdm = (n > 3) ? 1'b1 : (n < 3) ? 1'b0 : rd0;
        alt = (y == 7) && (kk || (!rdm && (x == 17 || x == 18 || x == 20)) ||
                           (rdm && (x == 11 || x == 13 || x == 14)));
        if (kk)       s4 = rdm ? ~kneg[y] : kneg[y];
        else if (alt) s4 = rdm ? 4'b1000 : 4'b0111;
        else          s4 = rdm ? dpos[y] : dneg[y];
        n = $countones({s6, s4});
        rd1 = (n == 6) ? 1'b1 : (n == 4) ? 1'b0 : rd0;
        return {k && !legal, rd1, s6, s4};
    endfunction

    task automatic drive(input logic [9:0] s, input logic k, input logic m,
                         input logic v, input logic byp, input string tag);
        exp_t e;
        logic rd0;
        logic [11:0] r;
        @(negedge clk);
        rst = 1'b0;
        sym_in = s; ctrl_k = k; disp_mode = m; disp_val = v; bypass = byp;
        if (byp) begin
            e.code = s; e.rd = model_rd; e.err = 1'b0;
        end else begin
            rd0 = m ? v : (v ? ~model_rd : model_rd);
            r = ref_enc(s[7:0], k, rd0);
            e.code = r[9:0]; e.rd = r[10]; e.err = r[11];
            model_rd = r[10];
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // monitor: one expected item per registered character
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                tests++;
                if (code_out !== e.code || run_disp !== e.rd || ctrl_err !== e.err) begin
                    fails++;
                    $display("FAIL %s: actual code=%b rd=%b err=%b expected code=%b rd=%b err=%b",
                             e.tag, code_out, run_disp, ctrl_err, e.code, e.rd, e.err);
                end
            end
        end
    end

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] kl [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(code_out, 0, "R1 code in reset");
        chk(run_disp, 0, "R1 disparity in reset");
        chk(ctrl_err, 0, "R1 error in reset");

        // R3: K28.5 from negative disparity, known pattern
        drive({2'b00, 8'hBC}, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        @(posedge clk); #1;
        chk(code_out, 10'b0011111010, "R9 R3 K28.5 first cycle after input");
        chk(run_disp, 1, "R5 R9 disparity after K28.5-");

        // R2: every data byte, twice to see both disparities
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 256; i++) drive({2'b00, i[7:0]}, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        // R6: alternate D.x.7 from both disparities
        for (int j = 0; j < 8; j++) begin
            drive({2'b00, 8'hF1}, 0, 1, j[0], 0, "R6 D17.7");
            drive({2'b00, 8'hEB}, 0, 1, j[1], 0, "R6 D11.7");
            drive({2'b00, 8'hF4}, 0, 1, j[2], 0, "R6 D20.7");
            drive({2'b00, 8'hED}, 0, 1, ~j[0], 0, "R6 D13.7");
        end
        // R3: all legal control characters
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 12; i++) drive({2'b00, kl[i]}, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        // R7: forced K28.5 ++ -- and inverted
        drive({2'b00, 8'hBC}, 1, 1, 1, 0, "R7 force pos");
        drive({2'b00, 8'hBC}, 1, 1, 1, 0, "R7 force pos");
        drive({2'b00, 8'hBC}, 1, 1, 0, 0, "R7 force neg");
        drive({2'b00, 8'hBC}, 1, 1, 0, 0, "R7 force neg");
        drive({2'b00, 8'hBC}, 1, 0, 1, 0, "R7 invert");
        drive({2'b00, 8'h00}, 0, 0, 1, 0, "R7 invert data");
        // R4: illegal control together with overrides, then a normal char
        drive({2'b00, 8'h00}, 1, 1, 1, 0, "R4 illegal forced pos");
        drive({2'b00, 8'h55}, 0, 0, 0, 0, "R4 error clears");
        drive({2'b00, 8'h1B}, 1, 1, 0, 0, "R4 illegal forced neg");
        drive({2'b00, 8'hF8}, 1, 0, 1, 0, "R4 illegal inverted");
        drive({2'b00, 8'h07}, 1, 0, 0, 0, "R4 illegal D7");
        // R8: bypass with other controls active
        drive(10'h3FF, 1, 1, 1, 1, "R8 bypass ones");
        drive(10'h000, 1, 0, 1, 1, "R8 bypass zeros");
        drive(10'h2A5, 0, 1, 0, 1, "R8 bypass pattern");
        drive({2'b00, 8'h03}, 0, 0, 0, 0, "R8 encode after bypass");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [9:0] s;
            logic k;
            r = $urandom;
            s = r[9:0];
            k = r[10];
            if (r[13:11] == 0) s[7:0] = kl[r[17:14] % 12];
            drive(s, k, r[18] & r[19], r[20], r[21] & r[22] & r[23], "R2 R7 random");
        end
        repeat (3) @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule